// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block holds the management statistics of a 10/100 Ethernet MAC. The receive and transmit paths each report events, such as a good frame, a CRC error or a collision, as single-cycle strobes. Each event type owns one bit of a strobe vector. Each strobe bit drives its own counter, and a counter that reaches the top of its range stays there.

Software reads a counter by giving its index on the read port. A global mode input decides what a read does to the counter. In the first mode the counter keeps its value. In the second mode the read zeroes the counter, so every read returns the events counted since the previous read.

Each counter has a sticky status bit. It sets once the counter's top bit is set, which is half of the counter's range. Software clears it by writing a 1. A mask chooses which status bits can raise the single interrupt line. A reset-all pulse zeroes every counter and every status bit in one cycle.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter and every status bit is 0, the enable mask is 0, `irq_o` is low and `rd_data_o` is 0.
- R2: Each clock in which bit i of `evt_i` is 1 adds one to counter i. Strobes on different bits in the same cycle are counted independently of each other.
- R3: A counter at all-ones stays at all-ones when further strobes arrive.
- R4: When `rd_en_i` is 1, `rd_data_o` shows counter `rd_idx_i` after the next clock edge. The value shown is the count from before that edge. An index of `NUM_CNT` or above returns 0. While `rd_en_i` is 0, `rd_data_o` holds its value.
- R5: When `cor_en_i` is 0, reading a counter leaves it unchanged.
- R6: When `cor_en_i` is 1, reading a valid index zeroes that counter. If a strobe for the same counter arrives in the same cycle, the counter is left at 1.
- R7: Status bit i is 1 on the clock edge after counter i has its most significant bit set. It stays 1 until it is cleared.
- R8: Writing a 1 to bit i of `sts_clr_i` clears status bit i, but only if counter i's most significant bit is clear at that time. Writing a 0 has no effect.
- R9: A pulse on `ien_wr_i` loads the whole enable mask from `ien_data_i`. `irq_o` is 1 exactly when some status bit and its enable bit are both 1.
- R10: A pulse on `clr_all_i` zeroes all counters and status bits on the next edge. It wins over strobes and clear-on-read in that cycle and leaves the enable mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CNT | Per-counter event strobes |
| cor_en_i | input | 1 | Global clear-on-read mode |
| clr_all_i | input | 1 | Zero all counters and status bits |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | IDX_W | Index of the counter to read |
| rd_data_o | output | CNT_W | Registered read data |
| ien_wr_i | input | 1 | Load the interrupt enable mask |
| ien_data_i | input | NUM_CNT | New interrupt enable mask |
| sts_clr_i | input | NUM_CNT | Write-1-to-clear for the status bits |
| sts_o | output | NUM_CNT | Sticky half-full status bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The states that are hardest to reach are the half-full mark and the saturation point. With 32-bit counters they need billions of strobes. The bench therefore builds the bank with 8-bit counters and drives one counter well past 128 and past 255. On the way it checks the moment the status bit sets. It then tries to clear the status bit while the top bit is still set, expecting the clear to have no effect. Finally it clears the counter with a read and clears the status bit, checking that the interrupt falls. Reads that coincide with a strobe, and a reset-all that coincides with strobes and reads, are each driven directly in a single cycle.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

  // Update chosen for one counter in one cycle
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_INC  = 2'd1,
    UPD_ZERO = 2'd2,
    UPD_ONE  = 2'd3
  } upd_e;

endpackage

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             rd_hit_i,
  input  logic             cor_i,
  input  logic             clr_all_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             half_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  upd_e             upd;
  logic             cnt_en;

  always_comb begin
    if (clr_all_i)                 upd = UPD_ZERO;
    else if (rd_hit_i && cor_i)    upd = inc_i ? UPD_ONE : UPD_ZERO;
    else if (inc_i && cnt_q != CNT_MAX) upd = UPD_INC;
    else                           upd = UPD_HOLD;
  end

  always_comb begin
    cnt_en = (upd != UPD_HOLD);
    unique case (upd)
      UPD_INC:  cnt_d = cnt_q + 1'b1;
      UPD_ZERO: cnt_d = '0;
      UPD_ONE:  cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign half_o = cnt_q[CNT_W-1];

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_all_i && !(rd_hit_i && cor_i) && cnt_q != CNT_MAX)
    |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_all_i && !(rd_hit_i && cor_i)) |=> (cnt_q == CNT_MAX));

  // R6
  cor_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_i && cor_i && inc_i && !clr_all_i) |=> (cnt_q == 1));

  // R10
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (cnt_q == '0));

endmodule

// File: rtl/mac_stat_irq.sv
module mac_stat_irq #(
  parameter int NUM_CNT = 47
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] half_i,
  input  logic [NUM_CNT-1:0] w1c_i,
  input  logic               clr_all_i,
  input  logic               ien_wr_i,
  input  logic [NUM_CNT-1:0] ien_data_i,
  output logic [NUM_CNT-1:0] sts_o,
  output logic               irq_o
);

  logic [NUM_CNT-1:0] sts_q, sts_d;
  logic [NUM_CNT-1:0] ien_q;

  always_comb begin
    if (clr_all_i) sts_d = '0;
    else           sts_d = half_i | (sts_q & ~w1c_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_q <= '0;
    else if (ien_wr_i) ien_q <= ien_data_i;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ien_q);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
    // R7
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[g] && !w1c_i[g] && !clr_all_i) |=> sts_q[g]);
    // R7
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_i[g] && !clr_all_i) |=> sts_q[g]);
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[g] && ien_q[g]) |-> irq_o);
  end

endmodule

// File: rtl/mac_stat_rdmux.sv
module mac_stat_rdmux #(
  parameter int NUM_CNT = 47,
  parameter int CNT_W   = 32,
  parameter int IDX_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_flat_i,
  input  logic                     rd_en_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [NUM_CNT-1:0]       rd_hit_o,
  output logic [CNT_W-1:0]         rd_data_o
);

  localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(NUM_CNT);

  logic             idx_ok;
  logic [CNT_W-1:0] sel_d, rd_q;

  assign idx_ok = ({1'b0, rd_idx_i} < IDX_LIM);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_dec
    assign rd_hit_o[g] = rd_en_i && (rd_idx_i == IDX_W'(g));
  end

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_idx_i == IDX_W'(i)) sel_d = cnt_flat_i[i*CNT_W +: CNT_W];
    end
    if (!idx_ok) sel_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= sel_d;
  end

  assign rd_data_o = rd_q;

  // R4
  rd_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !idx_ok) |=> (rd_data_o == '0));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

  // R4
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_hit_o));

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank #(
  parameter int NUM_CNT = 47,
  parameter int CNT_W   = 32,
  parameter int IDX_W   = $clog2(NUM_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               cor_en_i,
  input  logic               clr_all_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]   rd_data_o,
  input  logic               ien_wr_i,
  input  logic [NUM_CNT-1:0] ien_data_i,
  input  logic [NUM_CNT-1:0] sts_clr_i,
  output logic [NUM_CNT-1:0] sts_o,
  output logic               irq_o
);

  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic [NUM_CNT-1:0]       half;
  logic [NUM_CNT-1:0]       rd_hit;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
    mac_stat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (evt_i[g]),
      .rd_hit_i  (rd_hit[g]),
      .cor_i     (cor_en_i),
      .clr_all_i (clr_all_i),
      .cnt_o     (cnt_flat[g*CNT_W +: CNT_W]),
      .half_o    (half[g])
    );
  end

  mac_stat_rdmux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rdmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_flat_i (cnt_flat),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .rd_hit_o   (rd_hit),
    .rd_data_o  (rd_data_o)
  );

  mac_stat_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_i     (half),
    .w1c_i      (sts_clr_i),
    .clr_all_i  (clr_all_i),
    .ien_wr_i   (ien_wr_i),
    .ien_data_i (ien_data_i),
    .sts_o      (sts_o),
    .irq_o      (irq_o)
  );

endmodule

// File: tb/mac_stat_bank_tb.sv
module mac_stat_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 47;
  localparam int W  = 8;
  localparam int IW = $clog2(N);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  evt, ien_data, sts_clr, sts;
  logic          cor_en, clr_all, rd_en, ien_wr, irq;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  rd_data;

  logic [W-1:0]  exp_cnt [N];
  logic [N-1:0]  exp_sts, exp_ien;
  logic [W-1:0]  exp_rd;
  int            n_chk = 0, n_bad = 0;
  string         rd_tag = "R4";
  bit            finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_stat_bank #(.NUM_CNT(N), .CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cor_en_i(cor_en), .clr_all_i(clr_all),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .ien_wr_i(ien_wr),
    .ien_data_i(ien_data), .sts_clr_i(sts_clr), .sts_o(sts), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt = '0; clr_all = 0; rd_en = 0; rd_idx = '0;
    ien_wr = 0; ien_data = '0; sts_clr = '0;
  endtask

  // One clock: model update from the driven inputs, compare at the falling edge
  task automatic tick();
    logic [N-1:0] nsts;
    @(posedge clk);
    if (rd_en) exp_rd = (int'(rd_idx) < N) ? exp_cnt[int'(rd_idx)] : '0;
    for (int i = 0; i < N; i++) begin
      if (clr_all) nsts[i] = 1'b0;
      else nsts[i] = exp_cnt[i][W-1] | (exp_sts[i] & ~sts_clr[i]);
    end
    for (int i = 0; i < N; i++) begin
      if (clr_all) exp_cnt[i] = '0;
      else if (rd_en && int'(rd_idx) == i && cor_en) exp_cnt[i] = evt[i] ? W'(1) : '0;
      else if (evt[i] && exp_cnt[i] != MAXV) exp_cnt[i] = exp_cnt[i] + 1'b1;
    end
    exp_sts = nsts;
    if (ien_wr) exp_ien = ien_data;
    @(negedge clk);
    chk(rd_tag, 64'(rd_data), 64'(exp_rd));
    chk("R7", 64'(sts), 64'(exp_sts));
    chk("R9", 64'(irq), 64'(|(exp_sts & exp_ien)));
    idle_inputs();
  endtask

  task automatic read_all(input string tag);
    rd_tag = tag;
    for (int i = 0; i < N; i++) begin
      rd_en = 1; rd_idx = IW'(i);
      tick();
    end
    rd_tag = "R4";
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    cor_en = 0;
    rst_n = 0;
    for (int i = 0; i < N; i++) exp_cnt[i] = '0;
    exp_sts = '0; exp_ien = '0; exp_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", 64'(sts), 0);
    chk("R1", 64'(irq), 0);
    chk("R1", 64'(rd_data), 0);
    read_all("R1");

    // R2 mixed strobe patterns across all counters
    for (int c = 0; c < 120; c++) begin
      for (int i = 0; i < N; i++) evt[i] = ((c % (i % 7 + 1)) == 0) && (i != 46 || c < 5);
      tick();
    end
    read_all("R2");
    // R5 second pass sees the same counts
    read_all("R5");

    // R4 out-of-range index returns zero, hold when idle
    rd_en = 1; rd_idx = IW'(N); tick();
    rd_en = 1; rd_idx = IW'(63); tick();
    rd_en = 1; rd_idx = IW'(3); tick();
    tick(); tick();

    // R6 clear-on-read, then re-read shows zero
    cor_en = 1;
    read_all("R6");
    read_all("R6");
    // R6 read with same-cycle strobe leaves 1
    evt[10] = 1; rd_en = 1; rd_idx = IW'(10); tick();
    rd_tag = "R6"; rd_en = 1; rd_idx = IW'(10); tick(); rd_tag = "R4";
    chk("R6", 64'(rd_data), 1);
    cor_en = 0;

    // R9 enable counter 5 and counter 9
    ien_wr = 1; ien_data = '0; ien_data[5] = 1; ien_data[9] = 1; tick();
    // R7 R3 drive counter 5 through half-full and into saturation
    for (int c = 0; c < 300; c++) begin evt[5] = 1; evt[20] = 1; tick(); end
    rd_tag = "R3"; rd_en = 1; rd_idx = IW'(5); tick(); rd_tag = "R4";
    chk("R3", 64'(rd_data), 64'(MAXV));
    chk("R9", 64'(irq), 1);
    // R8 clear attempt while top bit still set
    sts_clr[5] = 1; sts_clr[20] = 1; tick();
    chk("R8", 64'(sts[5]), 1);
    chk("R8", 64'(sts[20]), 1);
    // R9 mask without the active bits
    ien_wr = 1; ien_data = '0; ien_data[0] = 1; tick();
    chk("R9", 64'(irq), 0);
    ien_wr = 1; ien_data = '0; ien_data[5] = 1; tick();
    // R8 clear after counter emptied by a clear-on-read
    cor_en = 1; rd_en = 1; rd_idx = IW'(5); tick(); cor_en = 0;
    sts_clr = '0; tick();
    chk("R8", 64'(sts[5]), 1);
    sts_clr[5] = 1; tick();
    chk("R8", 64'(sts[5]), 0);
    chk("R9", 64'(irq), 0);

    // R10 reset-all with strobes and a read in the same cycle
    for (int c = 0; c < 10; c++) begin evt = '1; tick(); end
    cor_en = 1; clr_all = 1; evt = '1; rd_en = 1; rd_idx = IW'(7); tick(); cor_en = 0;
    chk("R10", 64'(sts), 0);
    read_all("R10");
    chk("R10", 64'(irq), 0);
    // R10 enables kept: a new half-full on counter 5 raises irq
    for (int c = 0; c < 130; c++) begin evt[5] = 1; tick(); end
    tick();
    chk("R10", 64'(irq), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule